// File: doc/BRIEF.md
# Burst-read ROM target

This block is a read-only memory slave on a request/response bus with valid/acknowledge handshakes on both channels. Its contents are split into several separately mapped address segments. Each segment is a run of 32-bit words whose values are fixed when the design is elaborated. An initiator issues a single-flit read command that carries a byte address and a packet length in bytes. The block answers with a burst of response flits. For a 32-bit data path each flit carries one word. For a 64-bit data path each flit carries two words, and an odd word count ends with a half-filled flit.

A configurable number of upper address bits is cleared before segment matching. This lets one image answer at the same offset in every cluster whatever the cluster-ID bits of the address are. The block answers with a single error flit in these cases:

- the command is anything other than a read;
- the address misses every segment;
- the burst would run past the end of its segment;
- the address or length is misaligned, or the length is zero.

The source, thread and packet identifiers of the command are returned on every flit of the answer.

Top module: `burst_rom_target`

## Requirements
- R1: While reset is low, and on the first cycle after it, `rsp_val` is 0 and `cmd_ack` is 1.
- R2: `cmd_ack` is 1 exactly when no response is pending. A command is taken on a clock edge where `cmd_val` and `cmd_ack` are both 1, and its first response flit is valid on the next cycle. After the handshake of a last flit, `cmd_ack` is 1 again.
- R3: With the default map, segment 0 covers bytes 0x0000 to 0x003F (16 words), segment 1 covers 0x1000 to 0x107F (32 words), and segment 2 covers 0x3000 to 0x301F (8 words). Word i of segment s holds {8'h10+s, (i*3 mod 2^24) ^ 24'h3C5A00}. A burst that ends exactly at the end of a segment is served.
- R4: With a 32-bit data path, a read of PLEN bytes returns PLEN/4 flits, each carrying one word, in rising address order.
- R5: With a 64-bit data path and an even word count, a read returns PLEN/8 flits. Bits 31:0 carry the word at the lower address and bits 63:32 carry the next word.
- R6: With a 64-bit data path and an odd word count, a read returns PLEN/8+1 flits. The last flit carries its single word in bits 31:0, with bits 63:32 at zero.
- R7: The top DROP_MSB address bits (8 by default, bits 31:24) are ignored when matching segments. Bit 23 and the bits below it are still decoded.
- R8: `cmd_op` encodes read=0, write=1, load-linked=2, store-conditional=3, compare-and-swap=4. Any code other than read gets one flit with `rsp_err`=1, `rsp_eop`=1 and data zero.
- R9: A read whose masked address hits no segment, or whose burst passes the end of its segment, gets the same single error flit. So does a read with address bits 1:0 not zero, PLEN bits 1:0 not zero, or PLEN zero.
- R10: Every response flit carries the source, thread and packet identifiers of its command. `rsp_eop` is 1 only on the last flit of a burst.
- R11: A flit with `rsp_val`=1 and `rsp_ack`=0 is repeated unchanged on the next cycle. The burst advances only on a cycle where both are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_val | input | 1 | Command valid |
| cmd_ack | output | 1 | Command taken (block idle) |
| cmd_op | input | 3 | Command operation code |
| cmd_addr | input | ADDR_W | Byte address |
| cmd_plen | input | PLEN_W | Packet length in bytes |
| cmd_srcid | input | SRCID_W | Source identifier |
| cmd_trdid | input | TRDID_W | Thread identifier |
| cmd_pktid | input | PKTID_W | Packet identifier |
| rsp_val | output | 1 | Response flit valid |
| rsp_ack | input | 1 | Response flit accepted |
| rsp_data | output | DATA_W | Response data |
| rsp_err | output | 1 | Error flag |
| rsp_eop | output | 1 | Last flit of the response |
| rsp_srcid | output | SRCID_W | Echoed source identifier |
| rsp_trdid | output | TRDID_W | Echoed thread identifier |
| rsp_pktid | output | PKTID_W | Echoed packet identifier |

## Verification
The assertions assume that the initiator holds `rsp_ack` and the command fields at known levels while reset is released. They do not assume that `cmd_op`, the address or the length are legal, because illegal values have a defined error answer. The stimulus drives a new command only while the block is idle and drops `cmd_val` right after it is taken. It toggles `rsp_ack` pseudo-randomly so that holds and back-to-back acceptances both occur. One command stream feeds a 64-bit and a 32-bit instance, so that both packing rules see the same addresses, lengths, operation codes and misalignments.

// File: rtl/brom_pkg.sv
// Shared types and content rule for the burst-read ROM target.
// Assumes words are 32 bits; the content is a pure function of segment and index.
package brom_pkg;

    typedef enum logic [2:0] {
        OP_READ  = 3'd0,
        OP_WRITE = 3'd1,
        OP_LL    = 3'd2,
        OP_SC    = 3'd3,
        OP_CAS   = 3'd4
    } rom_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_ERROR
    } rsp_state_e;

    localparam int WORD_W = 32;

    // Fixed content of word idx in segment seg.
    function automatic logic [WORD_W-1:0] rom_word(input int unsigned seg,
                                                    input int unsigned idx);
        logic [23:0] low;
        low = 24'(idx * 3) ^ 24'h3C5A00;
        return {8'(32'h10 + seg), low};
    endfunction

endpackage

// File: rtl/brom_seg_decode.sv
// Segment matcher: masks the upper address bits, finds the lowest-numbered
// segment containing the address and checks that the whole burst fits.
// Assumes segments do not wrap the address space.
module brom_seg_decode #(
    parameter int ADDR_W    = 32,
    parameter int PLEN_W    = 8,
    parameter int NSEG      = 3,
    parameter int DROP_MSB  = 8,
    parameter int IDX_W     = 16,
    parameter int SEG_IDX_W = 2,
    parameter logic [NSEG-1:0][ADDR_W-1:0] SEG_BASE  = '0,
    parameter logic [NSEG-1:0][15:0]       SEG_WORDS = '0
) (
    input  logic [ADDR_W-1:0]    addr,
    input  logic [PLEN_W-1:0]    plen,
    output logic                 ok,
    output logic [SEG_IDX_W-1:0] seg_id,
    output logic [IDX_W-1:0]     word_off
);

    localparam logic [ADDR_W-1:0] KEEP_MASK = {ADDR_W{1'b1}} >> DROP_MSB;

    logic [ADDR_W-1:0] masked;
    logic [NSEG-1:0]   hit_vec;
    logic [NSEG-1:0]   fit_vec;
    logic [IDX_W-1:0]  off_vec [NSEG];
    logic              any_hit;
    logic              sel_fit;
    logic              aligned;

    assign masked = addr & KEEP_MASK;

    // One range comparator per segment.
    for (genvar s = 0; s < NSEG; s++) begin : g_seg
        localparam logic [ADDR_W:0] END_B =
            (ADDR_W+1)'(SEG_BASE[s]) + ((ADDR_W+1)'(SEG_WORDS[s]) << 2);
        assign hit_vec[s] = ({1'b0, masked} >= {1'b0, SEG_BASE[s]}) &&
                            ({1'b0, masked} <  END_B);
        assign fit_vec[s] = ({1'b0, masked} + (ADDR_W+1)'(plen)) <= END_B;
        assign off_vec[s] = IDX_W'((masked - SEG_BASE[s]) >> 2);
    end

    // Priority select: the lowest-numbered matching segment wins.
    always_comb begin
        seg_id   = '0;
        word_off = '0;
        sel_fit  = 1'b0;
        any_hit  = 1'b0;
        for (int s = NSEG - 1; s >= 0; s--) begin
            if (hit_vec[s]) begin
                seg_id   = SEG_IDX_W'(s);
                word_off = off_vec[s];
                sel_fit  = fit_vec[s];
                any_hit  = 1'b1;
            end
        end
    end

    assign aligned = (addr[1:0] == 2'b00) && (plen[1:0] == 2'b00) && (plen != '0);
    assign ok      = any_hit && sel_fit && aligned;

endmodule

// File: rtl/brom_word_store.sv
// Word store: presents the words of the current flit on the data lanes.
// Lanes beyond the words still owed are driven to zero, which gives the
// right-justified final half flit and an all-zero error flit.
module brom_word_store
    import brom_pkg::*;
#(
    parameter int DATA_W    = 64,
    parameter int SEG_IDX_W = 2,
    parameter int IDX_W     = 16,
    parameter int LEFT_W    = 8
) (
    input  logic [SEG_IDX_W-1:0] seg_id,
    input  logic [IDX_W-1:0]     word_idx,
    input  logic [LEFT_W-1:0]    words_left,
    output logic [DATA_W-1:0]    data
);

    localparam int LANES = DATA_W / WORD_W;

    // One content lookup per 32-bit lane.
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign data[k*WORD_W +: WORD_W] =
            (int'(words_left) > k) ? rom_word(int'(seg_id), int'(word_idx) + k)
                                   : '0;
    end

endmodule

// File: rtl/brom_rsp_ctrl.sv
// Response controller: the three-state FSM that accepts a command when idle,
// captures its identifiers and streams flits until the last one is accepted.
// Assumes the decode result is valid in the same cycle as the command.
module brom_rsp_ctrl
    import brom_pkg::*;
#(
    parameter int DATA_W    = 64,
    parameter int PLEN_W    = 8,
    parameter int SEG_IDX_W = 2,
    parameter int IDX_W     = 16,
    parameter int LEFT_W    = 8,
    parameter int SRCID_W   = 8,
    parameter int TRDID_W   = 4,
    parameter int PKTID_W   = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_val,
    input  logic [2:0]           cmd_op,
    input  logic [PLEN_W-1:0]    cmd_plen,
    input  logic [SRCID_W-1:0]   cmd_srcid,
    input  logic [TRDID_W-1:0]   cmd_trdid,
    input  logic [PKTID_W-1:0]   cmd_pktid,
    input  logic                 dec_ok,
    input  logic [SEG_IDX_W-1:0] dec_seg,
    input  logic [IDX_W-1:0]     dec_off,
    input  logic                 rsp_ack,
    output logic                 cmd_ack,
    output logic                 rsp_val,
    output logic                 rsp_err,
    output logic                 rsp_eop,
    output logic [SRCID_W-1:0]   rsp_srcid,
    output logic [TRDID_W-1:0]   rsp_trdid,
    output logic [PKTID_W-1:0]   rsp_pktid,
    output logic [SEG_IDX_W-1:0] cur_seg,
    output logic [IDX_W-1:0]     cur_idx,
    output logic [LEFT_W-1:0]    cur_left
);

    localparam int LANES = DATA_W / WORD_W;

    rsp_state_e state;
    logic       last_flit;

    assign last_flit = cur_left <= LEFT_W'(LANES);

    // State, burst position and identifier registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cur_seg   <= '0;
            cur_idx   <= '0;
            cur_left  <= '0;
            rsp_srcid <= '0;
            rsp_trdid <= '0;
            rsp_pktid <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (cmd_val) begin
                        rsp_srcid <= cmd_srcid;
                        rsp_trdid <= cmd_trdid;
                        rsp_pktid <= cmd_pktid;
                        if (cmd_op == OP_READ && dec_ok) begin
                            state    <= ST_READ;
                            cur_seg  <= dec_seg;
                            cur_idx  <= dec_off;
                            cur_left <= LEFT_W'(cmd_plen >> 2);
                        end else begin
                            state    <= ST_ERROR;
                            cur_left <= '0;
                        end
                    end
                end
                ST_READ: begin
                    if (rsp_ack) begin
                        if (last_flit) begin
                            state    <= ST_IDLE;
                            cur_left <= '0;
                        end else begin
                            cur_idx  <= cur_idx + IDX_W'(LANES);
                            cur_left <= cur_left - LEFT_W'(LANES);
                        end
                    end
                end
                ST_ERROR: begin
                    if (rsp_ack) begin
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Moore outputs of the controller.
    always_comb begin
        cmd_ack = (state == ST_IDLE);
        rsp_val = (state == ST_READ) || (state == ST_ERROR);
        rsp_err = (state == ST_ERROR);
        rsp_eop = (state == ST_ERROR) || ((state == ST_READ) && last_flit);
    end

endmodule

// File: rtl/burst_rom_target.sv
// Burst-read ROM target: a multi-segment read-only slave answering
// single-flit read commands with bursts of 32- or 64-bit flits.
// Assumes DATA_W is 32 or 64 and that segments do not overlap.
module burst_rom_target
    import brom_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 64,
    parameter int PLEN_W   = 8,
    parameter int SRCID_W  = 8,
    parameter int TRDID_W  = 4,
    parameter int PKTID_W  = 4,
    parameter int DROP_MSB = 8,
    parameter int NSEG     = 3,
    parameter int IDX_W    = 16,
    parameter logic [NSEG-1:0][ADDR_W-1:0] SEG_BASE =
        {32'h0000_3000, 32'h0000_1000, 32'h0000_0000},
    parameter logic [NSEG-1:0][15:0] SEG_WORDS = {16'd8, 16'd32, 16'd16}
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_val,
    output logic               cmd_ack,
    input  logic [2:0]         cmd_op,
    input  logic [ADDR_W-1:0]  cmd_addr,
    input  logic [PLEN_W-1:0]  cmd_plen,
    input  logic [SRCID_W-1:0] cmd_srcid,
    input  logic [TRDID_W-1:0] cmd_trdid,
    input  logic [PKTID_W-1:0] cmd_pktid,
    output logic               rsp_val,
    input  logic               rsp_ack,
    output logic [DATA_W-1:0]  rsp_data,
    output logic               rsp_err,
    output logic               rsp_eop,
    output logic [SRCID_W-1:0] rsp_srcid,
    output logic [TRDID_W-1:0] rsp_trdid,
    output logic [PKTID_W-1:0] rsp_pktid
);

    localparam int SEG_IDX_W = (NSEG > 1) ? $clog2(NSEG) : 1;
    localparam int LEFT_W    = PLEN_W;

    logic                 dec_ok;
    logic [SEG_IDX_W-1:0] dec_seg;
    logic [IDX_W-1:0]     dec_off;
    logic [SEG_IDX_W-1:0] cur_seg;
    logic [IDX_W-1:0]     cur_idx;
    logic [LEFT_W-1:0]    cur_left;

    brom_seg_decode #(
        .ADDR_W(ADDR_W), .PLEN_W(PLEN_W), .NSEG(NSEG), .DROP_MSB(DROP_MSB),
        .IDX_W(IDX_W), .SEG_IDX_W(SEG_IDX_W),
        .SEG_BASE(SEG_BASE), .SEG_WORDS(SEG_WORDS)
    ) u_decode (
        .addr     (cmd_addr),
        .plen     (cmd_plen),
        .ok       (dec_ok),
        .seg_id   (dec_seg),
        .word_off (dec_off)
    );

    brom_rsp_ctrl #(
        .DATA_W(DATA_W), .PLEN_W(PLEN_W), .SEG_IDX_W(SEG_IDX_W), .IDX_W(IDX_W),
        .LEFT_W(LEFT_W), .SRCID_W(SRCID_W), .TRDID_W(TRDID_W), .PKTID_W(PKTID_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_val   (cmd_val),
        .cmd_op    (cmd_op),
        .cmd_plen  (cmd_plen),
        .cmd_srcid (cmd_srcid),
        .cmd_trdid (cmd_trdid),
        .cmd_pktid (cmd_pktid),
        .dec_ok    (dec_ok),
        .dec_seg   (dec_seg),
        .dec_off   (dec_off),
        .rsp_ack   (rsp_ack),
        .cmd_ack   (cmd_ack),
        .rsp_val   (rsp_val),
        .rsp_err   (rsp_err),
        .rsp_eop   (rsp_eop),
        .rsp_srcid (rsp_srcid),
        .rsp_trdid (rsp_trdid),
        .rsp_pktid (rsp_pktid),
        .cur_seg   (cur_seg),
        .cur_idx   (cur_idx),
        .cur_left  (cur_left)
    );

    brom_word_store #(
        .DATA_W(DATA_W), .SEG_IDX_W(SEG_IDX_W), .IDX_W(IDX_W), .LEFT_W(LEFT_W)
    ) u_store (
        .seg_id     (cur_seg),
        .word_idx   (cur_idx),
        .words_left (cur_left),
        .data       (rsp_data)
    );

endmodule

// File: rtl/brom_checker.sv
// Protocol checker for the burst-read ROM target, bound to every instance.
// Assumes rsp_ack and the command fields are at known levels after reset.
module brom_checker #(
    parameter int DATA_W  = 64,
    parameter int SRCID_W = 8,
    parameter int TRDID_W = 4,
    parameter int PKTID_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cmd_val,
    input logic               cmd_ack,
    input logic [2:0]         cmd_op,
    input logic [SRCID_W-1:0] cmd_srcid,
    input logic [TRDID_W-1:0] cmd_trdid,
    input logic [PKTID_W-1:0] cmd_pktid,
    input logic               rsp_val,
    input logic               rsp_ack,
    input logic [DATA_W-1:0]  rsp_data,
    input logic               rsp_err,
    input logic               rsp_eop,
    input logic [SRCID_W-1:0] rsp_srcid,
    input logic [TRDID_W-1:0] rsp_trdid,
    input logic [PKTID_W-1:0] rsp_pktid
);

    assert_ack_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ack |-> !rsp_val);

    assert_return_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_val && rsp_ack && rsp_eop) |=> cmd_ack);

    assert_first_echo_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_val && cmd_ack) |=> (rsp_val && rsp_srcid == $past(cmd_srcid) &&
                                  rsp_trdid == $past(cmd_trdid) &&
                                  rsp_pktid == $past(cmd_pktid)));

    assert_burst_ids_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_val && rsp_ack && !rsp_eop) |=> (rsp_val && $stable(rsp_srcid) &&
                                              $stable(rsp_trdid) && $stable(rsp_pktid)));

    assert_bad_op_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_val && cmd_ack && cmd_op != 3'd0) |=> (rsp_val && rsp_err && rsp_eop &&
                                                    rsp_data == '0));

    assert_err_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_val && rsp_err) |-> rsp_eop);

    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_val && !rsp_ack) |=> (rsp_val && $stable(rsp_data) && $stable(rsp_err) &&
                                   $stable(rsp_eop) && $stable(rsp_srcid)));

endmodule

bind burst_rom_target brom_checker #(
    .DATA_W(DATA_W), .SRCID_W(SRCID_W), .TRDID_W(TRDID_W), .PKTID_W(PKTID_W)
) u_brom_checker (.*);

// File: tb/test_burst_rom_target.sv
// Bench: one command stream drives a 64-bit and a 32-bit instance; a
// behavioural model queues the expected flits and is compared every clock.
`timescale 1ns/1ps
module test_burst_rom_target;

    localparam int NITEM = 16;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmd_val;
    logic [2:0]  cmd_op;
    logic [31:0] cmd_addr;
    logic [7:0]  cmd_plen;
    logic [7:0]  cmd_srcid;
    logic [3:0]  cmd_trdid;
    logic [3:0]  cmd_pktid;

    logic        ack64, val64, err64, eop64, cack64;
    logic [63:0] data64;
    logic [7:0]  src64;
    logic [3:0]  trd64, pkt64;
    logic        ack32, val32, err32, eop32, cack32;
    logic [31:0] data32;
    logic [7:0]  src32;
    logic [3:0]  trd32, pkt32;

    always #4 clk = ~clk;

    burst_rom_target #(.DATA_W(64)) i_burst_rom_target (
        .clk(clk), .rst_n(rst_n), .cmd_val(cmd_val), .cmd_ack(cack64),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_plen(cmd_plen),
        .cmd_srcid(cmd_srcid), .cmd_trdid(cmd_trdid), .cmd_pktid(cmd_pktid),
        .rsp_val(val64), .rsp_ack(ack64), .rsp_data(data64), .rsp_err(err64),
        .rsp_eop(eop64), .rsp_srcid(src64), .rsp_trdid(trd64), .rsp_pktid(pkt64));

    burst_rom_target #(.DATA_W(32)) i_burst_rom_target_w32 (
        .clk(clk), .rst_n(rst_n), .cmd_val(cmd_val), .cmd_ack(cack32),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_plen(cmd_plen),
        .cmd_srcid(cmd_srcid), .cmd_trdid(cmd_trdid), .cmd_pktid(cmd_pktid),
        .rsp_val(val32), .rsp_ack(ack32), .rsp_data(data32), .rsp_err(err32),
        .rsp_eop(eop32), .rsp_srcid(src32), .rsp_trdid(trd32), .rsp_pktid(pkt32));

    int checks = 0;
    int errors = 0;

    logic [65:0] q64 [$];   // {err, eop, data}
    logic [33:0] q32 [$];
    bit          exp_err;

    int seg_base [3] = '{32'h0, 32'h1000, 32'h3000};
    int seg_size [3] = '{16, 32, 8};

    logic [2:0]  s_op   [NITEM];
    logic [31:0] s_addr [NITEM];
    logic [7:0]  s_plen [NITEM];
    string       s_tag  [NITEM];

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] exp_word(input int seg, input int idx);
        return {8'(16 + seg), 24'(idx * 3) ^ 24'h3C5A00};
    endfunction

    // Behavioural model: push the flits both widths must return.
    function automatic void model(input logic [2:0] op, input logic [31:0] addr,
                                  input logic [7:0] plen);
        int          seg = -1;
        logic [31:0] m = addr & 32'h00FF_FFFF;
        int          n = int'(plen) / 4;
        int          off;
        int          nf;
        bit          bad;
        for (int s = 0; s < 3; s++)
            if (seg < 0 && m >= seg_base[s] && m < seg_base[s] + 4 * seg_size[s]) seg = s;
        bad = (op != 3'd0) || (addr[1:0] != 0) || (plen[1:0] != 0) || (plen == 0) || (seg < 0);
        if (!bad) bad = (int'(m) + int'(plen)) > (seg_base[seg] + 4 * seg_size[seg]);
        exp_err = bad;
        if (bad) begin
            q64.push_back({1'b1, 1'b1, 64'h0});
            q32.push_back({1'b1, 1'b1, 32'h0});
            return;
        end
        off = (int'(m) - seg_base[seg]) / 4;
        for (int i = 0; i < n; i++)
            q32.push_back({1'b0, (i == n - 1), exp_word(seg, off + i)});
        nf = (n + 1) / 2;
        for (int f = 0; f < nf; f++) begin
            logic [31:0] hi;
            hi = (2 * f + 1 < n) ? exp_word(seg, off + 2 * f + 1) : 32'h0;
            q64.push_back({1'b0, (f == nf - 1), hi, exp_word(seg, off + 2 * f)});
        end
    endfunction

    initial begin
        int          item = 0;
        bit          pend = 0;
        int          cyc = 0;
        int          cur = 0;
        bit          idle64, idle32;
        logic [15:0] lfsr = 16'hACE1;
        string       tag64, tag32;

        s_op = '{0, 0, 0, 1, 2, 3, 4, 0, 0, 0, 0, 0, 0, 0, 0, 0};
        s_addr = '{32'h0000_0000, 32'h0000_1010, 32'h7A00_1004, 32'h0000_0000,
                   32'h0000_1000, 32'h0000_1000, 32'h0000_3000, 32'h0000_2000,
                   32'h0000_3018, 32'h0000_3018, 32'h0000_1002, 32'h0000_1000,
                   32'h0000_1000, 32'h0000_1000, 32'h0080_3000, 32'h0000_003C};
        s_plen = '{16, 12, 4, 4, 8, 4, 4, 4, 12, 8, 4, 6, 0, 128, 4, 4};
        s_tag = '{"R5", "R6", "R7", "R8", "R8", "R8", "R8", "R9",
                  "R9", "R3", "R9", "R9", "R9", "R5", "R7", "R6"};

        rst_n = 1'b0; cmd_val = 1'b0; cmd_op = '0; cmd_addr = '0; cmd_plen = '0;
        cmd_srcid = '0; cmd_trdid = '0; cmd_pktid = '0; ack64 = 1'b0; ack32 = 1'b0;
        tag64 = "R3"; tag32 = "R4";

        repeat (4) begin
            @(negedge clk);
            chk(!val64 && !val32, "R1 rsp_val in reset", {62'h0, val64, val32}, 64'h0);
            chk(cack64 && cack32, "R1 cmd_ack in reset", {62'h0, cack64, cack32}, 64'h3);
        end
        rst_n = 1'b1;

        while (!(item == NITEM && !pend && q64.size() == 0 && q32.size() == 0)) begin
            @(negedge clk);
            cyc++;
            if (cyc > 20000) begin
                chk(1'b0, "watchdog", 64'(cyc), 64'd20000);
                break;
            end
            if (pend) begin
                model(s_op[cur], s_addr[cur], s_plen[cur]);
                tag64 = s_tag[cur];
                tag32 = exp_err ? s_tag[cur] : "R4";
                cmd_val = 1'b0;
                pend = 0;
            end
            idle64 = (q64.size() == 0);
            idle32 = (q32.size() == 0);

            // 64-bit instance
            chk(cack64 == idle64, "R2 cmd_ack 64", 64'(cack64), 64'(idle64));
            chk(val64 == !idle64, "R11 rsp_val 64", 64'(val64), 64'(!idle64));
            if (val64 && !idle64) begin
                chk(data64 == q64[0][63:0], tag64, data64, q64[0][63:0]);
                chk(err64 == q64[0][65], tag64, 64'(err64), 64'(q64[0][65]));
                chk(eop64 == q64[0][64], "R10 eop 64", 64'(eop64), 64'(q64[0][64]));
                chk({src64, trd64, pkt64} == {cmd_srcid, cmd_trdid, cmd_pktid}, "R10 ids 64",
                    64'({src64, trd64, pkt64}), 64'({cmd_srcid, cmd_trdid, cmd_pktid}));
            end
            ack64 = lfsr[0];
            if (val64 && !idle64 && ack64) void'(q64.pop_front());

            // 32-bit instance
            chk(cack32 == idle32, "R2 cmd_ack 32", 64'(cack32), 64'(idle32));
            chk(val32 == !idle32, "R11 rsp_val 32", 64'(val32), 64'(!idle32));
            if (val32 && !idle32) begin
                chk(data32 == q32[0][31:0], tag32, 64'(data32), 64'(q32[0][31:0]));
                chk(err32 == q32[0][33], tag32, 64'(err32), 64'(q32[0][33]));
                chk(eop32 == q32[0][32], "R10 eop 32", 64'(eop32), 64'(q32[0][32]));
                chk({src32, trd32, pkt32} == {cmd_srcid, cmd_trdid, cmd_pktid}, "R10 ids 32",
                    64'({src32, trd32, pkt32}), 64'({cmd_srcid, cmd_trdid, cmd_pktid}));
            end
            ack32 = lfsr[3];
            if (val32 && !idle32 && ack32) void'(q32.pop_front());

            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};

            if (idle64 && idle32 && item < NITEM) begin
                cur       = item;
                cmd_op    = s_op[item];
                cmd_addr  = s_addr[item];
                cmd_plen  = s_plen[item];
                cmd_srcid = 8'(item * 7 + 3);
                cmd_trdid = 4'(item);
                cmd_pktid = 4'(15 - item);
                cmd_val   = 1'b1;
                pend      = 1;
                item++;
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule